// File: doc/BRIEF.md
# Clamping Signed Result Accumulator

This block keeps a running 32-bit total of signed 16-bit conversion results. Each result arrives on a valid/ready stream input. A 2-bit mode input picks the arithmetic. The total can be held at zero, summed with a floor at zero, or summed freely so that it can go negative. A fourth mode uses the floored arithmetic and also opens an interrupt-enable output, which a mask input gates.

The total is cleared by leaving the block in the off mode. To make that clear reliable, the block is not armed again until a fixed number of results (two by default) has been accepted while it is off. Results that arrive in an active mode before the block is armed are consumed and dropped. A sticky overflow flag reports a wrap of the total. The stream input never applies back-pressure: `res_ready` is high at all times, and every cycle with `res_valid` high transfers one result.

Top module: `clamp_accum`

## Requirements
- R1: `res_ready` is always 1. A result is accepted on any clock edge where `res_valid` is high. `total` changes only on an accepted result, or when the mode is 00, and the new value is visible after that edge.
- R2: Mode encoding: 00 = off, 01 = clamped, 10 = signed, 11 = clamped with interrupt. While the mode is 00, each clock edge sets `total` to 0 and clears `overflow`.
- R3: Each entry into mode 00 restarts an arming count. Accepted results while in mode 00 advance the count. Only after 2 of them does a later active mode accumulate. Results accepted in an active mode before then leave `total` unchanged.
- R4: Mode 01 treats `total` as unsigned. A non-negative result is added. The magnitude of a negative result is subtracted, and if it exceeds `total` the result is 0.
- R5: Mode 10 sign-extends the 16-bit two's-complement result to 32 bits and adds it with no floor, so `total` may go negative (two's complement).
- R6: Mode 11 uses the same arithmetic as mode 01. `irq_en` is 1 exactly when the mode is 11 and `irq_mask` is 1, and it follows the inputs in the same cycle.
- R7: `overflow` is set when a mode-10 addition wraps in signed terms (for example, after 65,539 results of +32767 starting from 0), or when a mode-01/11 addition carries out of bit 31. The total then wraps modulo 2^32. Once set, the flag stays set until mode 00 or reset.
- R8: An asynchronous active-low reset `rst_n` gives `total` = 0 and `overflow` = 0, and leaves the block unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Accumulation mode (00 off, 01 clamped, 10 signed, 11 clamped + interrupt) |
| irq_mask | input | 1 | Interrupt mask for mode 11 |
| res_valid | input | 1 | Conversion result valid |
| res_ready | output | 1 | Always high; no back-pressure |
| res_data | input | 16 | Signed conversion result |
| total | output | 32 | Running total |
| overflow | output | 1 | Sticky wrap indication |
| irq_en | output | 1 | Interrupt enable for mode 11 |

## Verification
The checker assumes the inputs carry known values after reset. The floor-at-zero property also assumes the total is never negative when a clamped mode starts. A negative total left by mode 10 would be read as a large unsigned value. To stay within that, the stimulus leaves mode 10 only through mode 00, or at a point where the total is still zero or positive. The overflow case runs only in mode 10, from a freshly cleared total.

// File: rtl/clamp_accum_pkg.sv
package clamp_accum_pkg;
  typedef enum logic [1:0] {
    ACC_OFF       = 2'b00,
    ACC_CLAMP     = 2'b01,
    ACC_SIGNED    = 2'b10,
    ACC_CLAMP_IRQ = 2'b11
  } acc_mode_e;
endpackage

// File: rtl/clamp_accum_arm.sv
// Tracks how many results were accepted since the last entry into the off
// mode; the accumulator is armed once that count reaches ARM_EVENTS.
module clamp_accum_arm #(
  parameter int ARM_EVENTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off,
  input  logic strobe,
  output logic armed
);
  localparam int CNT_W = $clog2(ARM_EVENTS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ARM_EVENTS);

  logic [CNT_W-1:0] cnt;
  logic             off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      off_q <= 1'b0;
    end else begin
      off_q <= off;
      if (off) begin
        if (!off_q)
          cnt <= strobe ? CNT_W'(1) : '0;
        else if (strobe && cnt != CNT_TOP)
          cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign armed = (cnt == CNT_TOP);
endmodule

// File: rtl/clamp_accum_alu.sv
// Next-total arithmetic for the clamped and signed modes.
module clamp_accum_alu
  import clamp_accum_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int ACC_W = 32
) (
  input  acc_mode_e         mode,
  input  logic [ACC_W-1:0]  acc,
  input  logic [RES_W-1:0]  res,
  output logic [ACC_W-1:0]  acc_nxt,
  output logic              wrap
);
  localparam int EXT_W = ACC_W - RES_W;
  localparam int MSB   = ACC_W - 1;

  logic             neg;
  logic [ACC_W-1:0] sext;
  logic [ACC_W-1:0] mag;
  logic [ACC_W:0]   usum;
  logic [ACC_W-1:0] ssum;

  always_comb begin
    neg     = res[RES_W-1];
    sext    = {{EXT_W{neg}}, res};
    mag     = ~sext + ACC_W'(1);
    usum    = {1'b0, acc} + {1'b0, sext};
    ssum    = acc + sext;
    acc_nxt = acc;
    wrap    = 1'b0;
    unique case (mode)
      ACC_SIGNED: begin
        acc_nxt = ssum;
        wrap    = (acc[MSB] == sext[MSB]) && (ssum[MSB] != acc[MSB]);
      end
      ACC_CLAMP, ACC_CLAMP_IRQ: begin
        if (neg) begin
          acc_nxt = (mag > acc) ? '0 : acc - mag;
        end else begin
          acc_nxt = usum[ACC_W-1:0];
          wrap    = usum[ACC_W];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/clamp_accum.sv
module clamp_accum
  import clamp_accum_pkg::*;
#(
  parameter int RES_W      = 16,
  parameter int ACC_W      = 32,
  parameter int ARM_EVENTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             irq_mask,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_data,
  output logic [ACC_W-1:0] total,
  output logic             overflow,
  output logic             irq_en
);
  acc_mode_e        mode_e;
  logic             off;
  logic             armed;
  logic             fire;
  logic [ACC_W-1:0] acc_nxt;
  logic             wrap;

  assign mode_e    = acc_mode_e'(mode);
  assign off       = (mode_e == ACC_OFF);
  assign res_ready = 1'b1;
  assign fire      = res_valid && res_ready && armed && !off;
  assign irq_en    = (mode_e == ACC_CLAMP_IRQ) && irq_mask;

  clamp_accum_arm #(.ARM_EVENTS(ARM_EVENTS)) u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .off    (off),
    .strobe (res_valid && res_ready),
    .armed  (armed)
  );

  clamp_accum_alu #(.RES_W(RES_W), .ACC_W(ACC_W)) u_alu (
    .mode    (mode_e),
    .acc     (total),
    .res     (res_data),
    .acc_nxt (acc_nxt),
    .wrap    (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total    <= '0;
      overflow <= 1'b0;
    end else if (off) begin
      total    <= '0;
      overflow <= 1'b0;
    end else if (fire) begin
      total    <= acc_nxt;
      overflow <= overflow | wrap;
    end
  end
endmodule

// File: rtl/clamp_accum_chk.sv
module clamp_accum_chk #(
  parameter int RES_W = 16,
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             res_valid,
  input logic [RES_W-1:0] res_data,
  input logic [ACC_W-1:0] total,
  input logic             overflow,
  input logic             armed
);
  assert_off_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> (total == '0) && !overflow);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && mode != 2'b00 |=> overflow);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b00 && !res_valid |=> $stable(total));

  assert_unarmed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b00 && !armed |=> $stable(total));

  assert_clamp_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 || mode == 2'b11) && res_valid && res_data[RES_W-1]
      |=> total <= $past(total));
endmodule

bind clamp_accum clamp_accum_chk #(.RES_W(RES_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .res_valid (res_valid),
  .res_data  (res_data),
  .total     (total),
  .overflow  (overflow),
  .armed     (armed)
);

// File: tb/clamp_accum_test.sv
`timescale 1ns/1ps
module clamp_accum_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        irq_mask = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [15:0] res_data = '0;
  logic [31:0] total;
  logic        overflow;
  logic        irq_en;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  clamp_accum uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .irq_mask(irq_mask),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .total(total), .overflow(overflow), .irq_en(irq_en)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic [1:0]  mode;
    logic        mask;
    logic        valid;
    logic [15:0] data;
    logic [31:0] total;
    logic        ovf;
    logic        irq;
  } row_t;

  localparam int NROWS = 24;
  localparam row_t TBL [NROWS] = '{
    '{"R3", 2'b00, 1'b0, 1'b1, 16'd5,    32'd0,         1'b0, 1'b0},
    '{"R3", 2'b00, 1'b0, 1'b1, 16'd5,    32'd0,         1'b0, 1'b0},
    '{"R4", 2'b01, 1'b0, 1'b1, 16'd100,  32'd100,       1'b0, 1'b0},
    '{"R4", 2'b01, 1'b0, 1'b1, 16'hFFE2, 32'd70,        1'b0, 1'b0},
    '{"R1", 2'b01, 1'b0, 1'b0, 16'd999,  32'd70,        1'b0, 1'b0},
    '{"R4", 2'b01, 1'b0, 1'b1, 16'hFF9C, 32'd0,         1'b0, 1'b0},
    '{"R4", 2'b01, 1'b0, 1'b1, 16'hFFFF, 32'd0,         1'b0, 1'b0},
    '{"R5", 2'b10, 1'b0, 1'b1, 16'd10,   32'd10,        1'b0, 1'b0},
    '{"R5", 2'b10, 1'b0, 1'b1, 16'hFFE7, 32'hFFFF_FFF1, 1'b0, 1'b0},
    '{"R5", 2'b10, 1'b0, 1'b1, 16'h8000, 32'hFFFF_7FF1, 1'b0, 1'b0},
    '{"R2", 2'b00, 1'b0, 1'b0, 16'd0,    32'd0,         1'b0, 1'b0},
    '{"R3", 2'b01, 1'b0, 1'b1, 16'd50,   32'd0,         1'b0, 1'b0},
    '{"R3", 2'b00, 1'b0, 1'b1, 16'd0,    32'd0,         1'b0, 1'b0},
    '{"R3", 2'b00, 1'b0, 1'b1, 16'd0,    32'd0,         1'b0, 1'b0},
    '{"R6", 2'b11, 1'b0, 1'b1, 16'd200,  32'd200,       1'b0, 1'b0},
    '{"R6", 2'b11, 1'b1, 1'b1, 16'hFFCE, 32'd150,       1'b0, 1'b1},
    '{"R6", 2'b11, 1'b1, 1'b1, 16'hFE0C, 32'd0,         1'b0, 1'b1},
    '{"R6", 2'b01, 1'b1, 1'b1, 16'h7FFF, 32'd32767,     1'b0, 1'b0},
    '{"R2", 2'b00, 1'b1, 1'b0, 16'd0,    32'd0,         1'b0, 1'b0},
    '{"R3", 2'b00, 1'b0, 1'b1, 16'd0,    32'd0,         1'b0, 1'b0},
    '{"R3", 2'b10, 1'b0, 1'b1, 16'd7,    32'd0,         1'b0, 1'b0},
    '{"R3", 2'b00, 1'b0, 1'b1, 16'd0,    32'd0,         1'b0, 1'b0},
    '{"R3", 2'b00, 1'b0, 1'b1, 16'd0,    32'd0,         1'b0, 1'b0},
    '{"R5", 2'b10, 1'b0, 1'b1, 16'd7,    32'd7,         1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic v, input logic [15:0] d);
    mode = m; res_valid = v; res_data = d;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8", "total", total, 32'd0);
    chk("R8", "overflow", {31'd0, overflow}, 32'd0);
    chk("R1", "ready", {31'd0, res_ready}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i].mode, TBL[i].valid, TBL[i].data);
      irq_mask = TBL[i].mask;
      @(negedge clk);
      chk(string'(TBL[i].tag), $sformatf("row %0d total", i), total, TBL[i].total);
      chk(string'(TBL[i].tag), $sformatf("row %0d overflow", i), {31'd0, overflow}, {31'd0, TBL[i].ovf});
      chk("R6", $sformatf("row %0d irq_en", i), {31'd0, irq_en}, {31'd0, TBL[i].irq});
    end

    // R7: signed wrap after 65,539 results of +32767
    irq_mask = 1'b0;
    drive(2'b00, 1'b1, 16'd0);
    repeat (2) @(negedge clk);
    drive(2'b10, 1'b1, 16'h7FFF);
    repeat (65538) @(negedge clk);
    chk("R7", "total before wrap", total, 32'd2147483646);
    chk("R7", "no overflow yet", {31'd0, overflow}, 32'd0);
    @(negedge clk);
    chk("R7", "total after wrap", total, 32'h8000_7FFD);
    chk("R7", "overflow set", {31'd0, overflow}, 32'd1);
    drive(2'b10, 1'b1, 16'hFFFF);
    @(negedge clk);
    chk("R7", "total after -1", total, 32'h8000_7FFC);
    chk("R7", "overflow sticky", {31'd0, overflow}, 32'd1);
    drive(2'b10, 1'b0, 16'd0);
    @(negedge clk);
    chk("R1", "idle hold", total, 32'h8000_7FFC);
    drive(2'b00, 1'b0, 16'd0);
    @(negedge clk);
    chk("R2", "off clears total", total, 32'd0);
    chk("R2", "off clears overflow", {31'd0, overflow}, 32'd0);

    // R8: reset mid-run, then unarmed afterwards
    drive(2'b00, 1'b1, 16'd0);
    repeat (2) @(negedge clk);
    drive(2'b01, 1'b1, 16'd123);
    @(negedge clk);
    chk("R4", "armed add", total, 32'd123);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8", "reset clears", total, 32'd0);
    rst_n = 1'b1;
    drive(2'b01, 1'b1, 16'd5);
    @(negedge clk);
    chk("R8", "unarmed after reset", total, 32'd0);

    summary();
  end
endmodule